// File: doc/BRIEF.md
# Terminal-Count Reload Clock Divider

This block divides a fast clock by a programmable even ratio from 4 to 1024. An 8-bit up-counter moves forward once every second input clock. When it reaches its all-ones terminal value it raises an active-low flag. On its next advance the counter reloads the programmed start value N instead of wrapping. A single register samples the flag and inverts it, giving an active-high strobe. That strobe drives both inputs of a J/K-style toggle stage, so the stage flips once for every terminal count. The toggle output is a square wave at the input clock divided by 4×(256−N).

Every register runs on the one fast clock and advances only under a clock enable. There are no derived clocks. The start value is a plain control input. It is sampled only at the reload instant, so software may change it at any time. There is no data stream and no handshake. The divided clock and the strobe are plain outputs with no back-pressure.

Top module: `tcr_clock_divider`

## Requirements
- R1: While `rst_ni` is low, `div_clk_o` and `tc_stb_o` are 0.
- R2: Once the first half-period after reset is over, the period of `div_clk_o` is exactly 4×(256−N) input clocks, where N is the unsigned value on `reload_val_i`. N=255 gives 4 and N=0 gives 1024.
- R3: `div_clk_o` is high for exactly 2×(256−N) input clocks of each period.
- R4: `div_clk_o` changes only on a rising clock edge where `tc_stb_o` was 1 during the preceding cycle.
- R5: The counter advances only on every second input clock. For N below 255, each `tc_stb_o` pulse lasts exactly 2 input clocks. For N=255, `tc_stb_o` stays 1 once running.
- R6: A new N takes effect only at the next reload. A half-period already under way keeps its old length, and the half-periods after it use the new length.
- R7: Reset clears the counter to 0 whatever N is. After `rst_ni` rises, the first rising edge of `div_clk_o` therefore comes on the 514th rising clock edge.
- R8: For N below 255, rising edges of `tc_stb_o` are 2×(256−N) input clocks apart, and each one follows a cycle in which the terminal-count flag was active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reload_val_i | input | CNT_W (8) | Start value N, loaded at each terminal count |
| div_clk_o | output | 1 | Divided square-wave clock |
| tc_stb_o | output | 1 | Registered, inverted terminal-count strobe |

## Verification
Each result has a fixed latency:

| Event | Clock edges |
|---|---|
| Terminal value reached to strobe set | 2 |
| Strobe set to toggle of `div_clk_o` | 2 |
| Reset release to first rise of `div_clk_o` | 514 |

The bench releases reset just after a falling edge and counts rising edges from that point. It samples every output at the falling edge that follows the edge being counted, so each measured interval is a whole number of clocks and can be compared exactly. Periods, high times and strobe spacing are taken only after the first half-period, because that one always starts from zero. The stable-N check changes N a known 20 clocks after a toggle, which is after the reload of that half-period has already happened.

// File: rtl/tcr_div_pkg.sv
package tcr_div_pkg;
  // Default counter width; ratio spans 4 .. 4*2**CNT_W
  localparam int unsigned DEF_CNT_W = 8;
  // Input pair of the toggle stage, written {j,k}
  typedef enum logic [1:0] {
    JK_HOLD   = 2'b00,
    JK_CLEAR  = 2'b01,
    JK_SET    = 2'b10,
    JK_TOGGLE = 2'b11
  } jk_cmd_e;
endpackage

// File: rtl/tcr_ce_prescaler.sv
module tcr_ce_prescaler #(
  parameter int unsigned PRE_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ce_o
);
  generate
    if (PRE_DIV <= 1) begin : g_pass
      assign ce_o = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(PRE_DIV);
      localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
      logic [PW-1:0] ph_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           ph_q <= '0;
        else if (ph_q == LAST) ph_q <= '0;
        else                   ph_q <= ph_q + 1'b1;
      end
      assign ce_o = (ph_q == LAST);

      AST_CE_GAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ce_o |=> !ce_o); // R5
    end
  endgenerate
endmodule

// File: rtl/tcr_reload_counter.sv
module tcr_reload_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             tc_n_o
);
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t TERM = '1;

  cnt_t count_q;
  logic at_term;

  assign at_term = (count_q == TERM);
  assign tc_n_o  = ~at_term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '0;
    else if (ce_i) begin
      if (at_term)    count_q <= load_i;
      else            count_q <= count_q + 1'b1;
    end
  end

  AST_COUNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ce_i) |-> $stable(count_q)); // R5
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ce_i) && $past(count_q) != TERM) |-> count_q == cnt_t'($past(count_q) + 1'b1)); // R2
  AST_RELOAD_VAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ce_i) && $past(count_q) == TERM) |-> count_q == $past(load_i)); // R6
endmodule

// File: rtl/tcr_tc_pipe.sv
module tcr_tc_pipe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic tc_n_i,
  output logic stb_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   stb_o <= 1'b0;
    else if (ce_i) stb_o <= ~tc_n_i;
  end

  AST_STB_AFTER_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stb_o) |-> $past(!tc_n_i)); // R8
endmodule

// File: rtl/tcr_toggle_stage.sv
module tcr_toggle_stage
  import tcr_div_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic stb_i,
  output logic q_o
);
  jk_cmd_e cmd;
  assign cmd = jk_cmd_e'({stb_i, stb_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else if (ce_i) begin
      unique case (cmd)
        JK_HOLD:   q_o <= q_o;
        JK_CLEAR:  q_o <= 1'b0;
        JK_SET:    q_o <= 1'b1;
        JK_TOGGLE: q_o <= ~q_o;
      endcase
    end
  end

  AST_TOGGLE_NEEDS_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o != $past(q_o)) |-> $past(stb_i)); // R4
endmodule

// File: rtl/tcr_clock_divider.sv
module tcr_clock_divider
  import tcr_div_pkg::*;
#(
  parameter int unsigned CNT_W   = DEF_CNT_W,
  parameter int unsigned PRE_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic             div_clk_o,
  output logic             tc_stb_o
);
  logic ce, tc_n, stb;

  tcr_ce_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_o(ce));

  tcr_reload_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce),
    .load_i(reload_val_i), .tc_n_o(tc_n));

  tcr_tc_pipe u_pipe (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce),
    .tc_n_i(tc_n), .stb_o(stb));

  tcr_toggle_stage u_tog (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce),
    .stb_i(stb), .q_o(div_clk_o));

  assign tc_stb_o = stb;
endmodule

// File: tb/tcr_clock_divider_tb_top.sv
`timescale 1ns/1ps
module tcr_clock_divider_tb_top;
  localparam int NENT = 6;
  localparam int unsigned NV [NENT] = '{255, 254, 200, 128, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] nval = 8'd0;
  logic div_clk, tc_stb;
  int cyc = 0, base = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit prev_div = 1'b0, prev_stb = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tcr_clock_divider dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reload_val_i(nval),
    .div_clk_o(div_clk), .tc_stb_o(tc_stb));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R4 monitor: every toggle of div_clk must follow a cycle with the strobe high
  always @(negedge clk) begin
    if (rst_n && (div_clk != prev_div))
      check(prev_stb == 1'b1, "R4", prev_stb, 1);
    prev_div = div_clk;
    prev_stb = tc_stb;
  end

  task automatic wait_div(input bit lvl, output int t);
    do @(negedge clk); while (div_clk !== lvl);
    t = cyc;
  endtask

  task automatic wait_stb(input bit lvl, output int t);
    do @(negedge clk); while (tc_stb !== lvl);
    t = cyc;
  endtask

  task automatic do_reset(input int n);
    rst_n = 1'b0;
    nval = 8'(n);
    repeat (4) @(negedge clk);
    check(div_clk == 1'b0, "R1 div_clk", div_clk, 0);
    check(tc_stb == 1'b0, "R1 tc_stb", tc_stb, 0);
    rst_n = 1'b1;
    base = cyc;
  endtask

  initial begin
    int t0, t1, t2, f1, r2, f2, r3, zeros;
    for (int i = 0; i < NENT; i++) begin
      int n = int'(NV[i]);
      do_reset(n);
      wait_div(1'b1, t0);
      check(t0 - base == 514, "R7 first rise", t0 - base, 514);
      wait_div(1'b0, f1);
      wait_div(1'b1, r2);
      wait_div(1'b0, f2);
      wait_div(1'b1, r3);
      check(r3 - r2 == 4 * (256 - n), "R2 period", r3 - r2, 4 * (256 - n));
      check(f2 - r2 == 2 * (256 - n), "R3 high time", f2 - r2, 2 * (256 - n));
    end

    // R5 / R8: strobe width and spacing for N=0
    do_reset(0);
    wait_div(1'b1, t0);
    wait_stb(1'b1, t1);
    wait_stb(1'b0, t2);
    check(t2 - t1 == 2, "R5 strobe width", t2 - t1, 2);
    wait_stb(1'b1, t2);
    check(t2 - t1 == 512, "R8 strobe spacing", t2 - t1, 512);

    // R8 spacing for N=128
    do_reset(128);
    wait_div(1'b1, t0);
    wait_stb(1'b1, t1);
    wait_stb(1'b0, t2);
    wait_stb(1'b1, t2);
    check(t2 - t1 == 256, "R8 strobe spacing N=128", t2 - t1, 256);

    // R5: N=255 keeps the strobe high continuously
    do_reset(255);
    wait_div(1'b1, t0);
    zeros = 0;
    repeat (40) begin
      @(negedge clk);
      if (tc_stb !== 1'b1) zeros++;
    end
    check(zeros == 0, "R5 strobe held for N=255", zeros, 0);

    // R6: change N in mid half-period
    do_reset(200);
    wait_div(1'b1, t0);
    wait_div(1'b0, t0);
    repeat (20) @(negedge clk);
    nval = 8'd250;
    wait_div(1'b1, t1);
    check(t1 - t0 == 112, "R6 old half-period kept", t1 - t0, 112);
    wait_div(1'b0, t2);
    check(t2 - t1 == 12, "R6 new half-period", t2 - t1, 12);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule